// File: doc/BRIEF.md
# Two-Wire Bus State Monitor

This block watches a two-wire serial bus without driving it. It samples the clock line and the data line, passes each through its own synchronizer, and moves a ten-state machine by looking up a transition table. The table is indexed by the current state and the sampled line pair. Each table entry holds the next state and six status flags. The flags are registered together with the state, so every output comes straight from a flop.

With its reset contents, the table follows the start, bit-cell and stop phases of an I2C conversation. It also recognizes a clock-first, SPI-style burst. If both lines change between two samples, the bus glitched or the sampling was too slow. The machine then enters a trap state and stays there until reset.

The table can be rewritten entry by entry through a write port, so the same engine can follow other two-line protocols. Byte, address and acknowledge decoding is left to other logic.

Top module: `twowire_state_monitor`

## Requirements
- R1: After reset, idle_o is 1 and start_o, i2c_busy_o, spi_busy_o, stop_o and error_o are 0. The table holds its default contents.
- R2: A change on scl_i/sda_i first shows on the outputs after the third rising clock edge. Two edges are spent in the synchronizer and one in the state register. After only two edges, the outputs still show the old value.
- R3: From idle (both lines high), sda_i falling while scl_i stays high raises start_o for exactly one cycle. i2c_busy_o is raised at the same time and stays high.
- R4: During an I2C transfer, i2c_busy_o stays high and idle_o stays low while the lines move through the bit-cell states: both low, clock high with data low, clock low with data high, and both high.
- R5: sda_i rising while scl_i is high raises stop_o for one cycle and sets idle_o. This applies when the bus came from clock high with data low: the start-hold state, a data bit cell, or the clock-first path.
- R6: From the both-high state inside a transfer, sda_i falling with scl_i high gives a repeated start. start_o pulses again and i2c_busy_o stays high.
- R7: From idle, scl_i falling first raises spi_busy_o. It stays high through the clock-first states. Going back to both high directly from clock-low/data-high gives idle_o with no stop pulse.
- R8: If both lines change within one sample, error_o goes to 1 and every other output goes to 0. The state is then held for every line value until rst_ni is asserted.
- R9: A write at tbl_addr_i = {state[3:0], scl, sda} stores tbl_data_i. The entry layout is [3:0] next state, [4] error, [5] idle, [6] stop, [7] SPI-busy, [8] I2C-busy, [9] start. The new entry takes effect the next time that state/input pair is seen. Reset restores the default table.
- R10: If a table entry names a next state of 10 or more, the machine goes to the trap state and drives error_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line (index bit 1) |
| sda_i | input | 1 | Bus data line (index bit 0) |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 6 | Table entry address {state, scl, sda} |
| tbl_data_i | input | 10 | Table entry: flags in [9:4], next state in [3:0] |
| start_o | output | 1 | Start or repeated start pulse |
| i2c_busy_o | output | 1 | I2C transfer in progress |
| spi_busy_o | output | 1 | Clock-first burst in progress |
| stop_o | output | 1 | Stop pulse |
| idle_o | output | 1 | Bus idle |
| error_o | output | 1 | Sticky simultaneous-change error |

## Verification
Each line change is made just after a falling edge. Its effect is due after the third rising edge: two synchronizer stages, then the state and flag register. The bench therefore waits three rising edges and samples at the next falling edge. One check instead samples after only two rising edges, to confirm the old value is still there. Start and stop pulses are checked in their due cycle and again one cycle later, to confirm they lasted exactly one cycle. A table write lands on the rising edge after its strobe, and the bench only changes the lines after that edge.

// File: rtl/twm_pkg.sv
`timescale 1ns/1ps
package twm_pkg;
  localparam int unsigned NUM_ST    = 10;
  localparam int unsigned ST_W      = 4;
  localparam int unsigned IN_W      = 2;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned ENT_W     = ST_W + NUM_FLAGS;
  localparam int unsigned ADDR_W    = ST_W + IN_W;
  localparam int unsigned DEPTH     = NUM_ST * (1 << IN_W);

  localparam logic [ST_W-1:0] ST_IDLE = 4'd0; // both high
  localparam logic [ST_W-1:0] ST_STRT = 4'd1; // start hold, 10
  localparam logic [ST_W-1:0] ST_B00  = 4'd2;
  localparam logic [ST_W-1:0] ST_B01  = 4'd3;
  localparam logic [ST_W-1:0] ST_B10  = 4'd4;
  localparam logic [ST_W-1:0] ST_B11  = 4'd5;
  localparam logic [ST_W-1:0] ST_R01  = 4'd6; // clock-first path
  localparam logic [ST_W-1:0] ST_R00  = 4'd7;
  localparam logic [ST_W-1:0] ST_R10  = 4'd8;
  localparam logic [ST_W-1:0] ST_TRAP = 4'd9;
  localparam logic [ST_W-1:0] ST_LAST = ST_TRAP;

  typedef struct packed {
    logic start;
    logic i2c;
    logic spi;
    logic stop;
    logic idle;
    logic err;
  } flags_t;

  typedef struct packed {
    flags_t            flags;
    logic [ST_W-1:0]   nxt;
  } entry_t;

  localparam flags_t FLAGS_IDLE = '{start:1'b0, i2c:1'b0, spi:1'b0, stop:1'b0, idle:1'b1, err:1'b0};
  localparam flags_t FLAGS_ERR  = '{start:1'b0, i2c:1'b0, spi:1'b0, stop:1'b0, idle:1'b0, err:1'b1};

  function automatic logic [ST_W-1:0] dflt_next(logic [ST_W-1:0] s, logic [IN_W-1:0] ln);
    logic [ST_W-1:0] n;
    n = ST_TRAP;
    case (s)
      ST_IDLE: case (ln) 2'b11: n = ST_IDLE; 2'b10: n = ST_STRT; 2'b01: n = ST_R01; default: n = ST_TRAP; endcase
      ST_STRT: case (ln) 2'b10: n = ST_STRT; 2'b00: n = ST_B00;  2'b11: n = ST_IDLE; default: n = ST_TRAP; endcase
      ST_B00:  case (ln) 2'b00: n = ST_B00;  2'b01: n = ST_B01;  2'b10: n = ST_B10;  default: n = ST_TRAP; endcase
      ST_B01:  case (ln) 2'b01: n = ST_B01;  2'b11: n = ST_B11;  2'b00: n = ST_B00;  default: n = ST_TRAP; endcase
      ST_B10:  case (ln) 2'b10: n = ST_B10;  2'b11: n = ST_IDLE; 2'b00: n = ST_B00;  default: n = ST_TRAP; endcase
      ST_B11:  case (ln) 2'b11: n = ST_B11;  2'b01: n = ST_B01;  2'b10: n = ST_STRT; default: n = ST_TRAP; endcase
      ST_R01:  case (ln) 2'b01: n = ST_R01;  2'b00: n = ST_R00;  2'b11: n = ST_IDLE; default: n = ST_TRAP; endcase
      ST_R00:  case (ln) 2'b00: n = ST_R00;  2'b10: n = ST_R10;  2'b01: n = ST_R01;  default: n = ST_TRAP; endcase
      ST_R10:  case (ln) 2'b10: n = ST_R10;  2'b11: n = ST_IDLE; 2'b00: n = ST_R00;  default: n = ST_TRAP; endcase
      default: n = ST_TRAP;
    endcase
    return n;
  endfunction

  function automatic entry_t dflt_entry(logic [ST_W-1:0] s, logic [IN_W-1:0] ln);
    entry_t e;
    logic   from_hi_lo;
    e.nxt      = dflt_next(s, ln);
    from_hi_lo = (s == ST_STRT) || (s == ST_B10) || (s == ST_R10);
    e.flags.err   = (e.nxt == ST_TRAP);
    e.flags.idle  = (e.nxt == ST_IDLE);
    e.flags.i2c   = (e.nxt >= ST_STRT) && (e.nxt <= ST_B11);
    e.flags.spi   = (e.nxt >= ST_R01) && (e.nxt <= ST_R10);
    e.flags.start = (e.nxt == ST_STRT) && (s != ST_STRT);
    e.flags.stop  = (e.nxt == ST_IDLE) && from_hi_lo;
    return e;
  endfunction
endpackage

// File: rtl/twm_sync.sv
`timescale 1ns/1ps
module twm_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/twm_table.sv
`timescale 1ns/1ps
module twm_table
  import twm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  entry_t            wdata_i,
  input  logic [ST_W-1:0]   rd_st_i,
  input  logic [IN_W-1:0]   rd_in_i,
  output entry_t            rdata_o
);
  entry_t mem_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam logic [ST_W-1:0] ROW_ST = ST_W'(gi / 4);
    localparam logic [IN_W-1:0] ROW_IN = IN_W'(gi % 4);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[gi] <= dflt_entry(ROW_ST, ROW_IN);
      else if (we_i && (waddr_i == ADDR_W'(gi))) mem_q[gi] <= wdata_i;
    end

    AST_TBL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i == ADDR_W'(gi)) |=> (mem_q[gi] == $past(wdata_i))); // R9
  end

  logic [ADDR_W-1:0] rd_idx;
  assign rd_idx = {rd_st_i, rd_in_i};

  always_comb begin
    rdata_o       = '0;
    rdata_o.nxt   = ST_TRAP;
    rdata_o.flags = FLAGS_ERR;
    if (rd_idx < ADDR_W'(DEPTH)) rdata_o = mem_q[rd_idx];
  end
endmodule

// File: rtl/twm_engine.sv
`timescale 1ns/1ps
module twm_engine
  import twm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] line_i,
  input  entry_t          entry_i,
  output logic [ST_W-1:0] st_o,
  output flags_t          flags_o
);
  logic [ST_W-1:0] st_q, st_d;
  flags_t          fl_q, fl_d;

  always_comb begin
    if (st_q == ST_TRAP || entry_i.nxt > ST_LAST) begin
      st_d = ST_TRAP;
      fl_d = FLAGS_ERR;
    end else begin
      st_d = entry_i.nxt;
      fl_d = entry_i.flags;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      fl_q <= FLAGS_IDLE;
    end else begin
      st_q <= st_d;
      fl_q <= fl_d;
    end
  end

  assign st_o    = st_q;
  assign flags_o = fl_q;

  AST_TRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRAP) |=> (st_q == ST_TRAP)); // R8
  AST_TRAP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRAP) |-> (fl_q.err && !fl_q.idle && !fl_q.i2c && !fl_q.spi)); // R8
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q <= ST_LAST)); // R10
  AST_BAD_NEXT_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_i.nxt > ST_LAST) |=> (st_q == ST_TRAP)); // R10
  AST_LINE_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(line_i)); // R2
endmodule

// File: rtl/twowire_state_monitor.sv
`timescale 1ns/1ps
module twowire_state_monitor
  import twm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              tbl_we_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [ENT_W-1:0]  tbl_data_i,
  output logic              start_o,
  output logic              i2c_busy_o,
  output logic              spi_busy_o,
  output logic              stop_o,
  output logic              idle_o,
  output logic              error_o
);
  logic [IN_W-1:0] line_s;
  logic [ST_W-1:0] st;
  entry_t          ent;
  entry_t          wr_ent;
  flags_t          fl;

  assign wr_ent = entry_t'(tbl_data_i);

  twm_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  twm_table u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .waddr_i(tbl_addr_i),
    .wdata_i(wr_ent),
    .rd_st_i(st),
    .rd_in_i(line_s),
    .rdata_o(ent)
  );

  twm_engine u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_s),
    .entry_i(ent),
    .st_o   (st),
    .flags_o(fl)
  );

  assign start_o    = fl.start;
  assign i2c_busy_o = fl.i2c;
  assign spi_busy_o = fl.spi;
  assign stop_o     = fl.stop;
  assign idle_o     = fl.idle;
  assign error_o    = fl.err;
endmodule

// File: tb/twowire_state_monitor_tb_top.sv
`timescale 1ns/1ps
module twowire_state_monitor_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic       tbl_we_i = 1'b0;
  logic [5:0] tbl_addr_i = '0;
  logic [9:0] tbl_data_i = '0;
  logic start_o, i2c_busy_o, spi_busy_o, stop_o, idle_o, error_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  twowire_state_monitor dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i),
    .start_o(start_o), .i2c_busy_o(i2c_busy_o), .spi_busy_o(spi_busy_o),
    .stop_o(stop_o), .idle_o(idle_o), .error_o(error_o)
  );

  // order: {start, i2c, spi, stop, idle, error}
  localparam logic [5:0] O_IDLE = 6'b000010;
  localparam logic [5:0] O_STRT = 6'b110000;
  localparam logic [5:0] O_I2C  = 6'b010000;
  localparam logic [5:0] O_SPI  = 6'b001000;
  localparam logic [5:0] O_STOP = 6'b000110;
  localparam logic [5:0] O_ERR  = 6'b000001;

  task automatic check(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {start_o, i2c_busy_o, spi_busy_o, stop_o, idle_o, error_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; result due after third rising edge
  task automatic step(logic scl, logic sda, string req, logic [5:0] exp);
    scl_i = scl;
    sda_i = sda;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(req, exp);
  endtask

  task automatic hold(string req, logic [5:0] exp);
    @(negedge clk_i);
    check(req, exp);
  endtask

  task automatic do_reset();
    scl_i  = 1'b1;
    sda_i  = 1'b1;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic tbl_write(logic [5:0] addr, logic [9:0] data);
    tbl_we_i   = 1'b1;
    tbl_addr_i = addr;
    tbl_data_i = data;
    @(posedge clk_i);
    @(negedge clk_i);
    tbl_we_i   = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset", O_IDLE);
  endtask

  task automatic t_latency();
    scl_i = 1'b1;
    sda_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R2 two edges", O_IDLE);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R2 third edge", O_STRT);
    hold("R3 start one cycle", O_I2C);
    step(1'b1, 1'b1, "R5 stop from start hold", O_STOP);
    hold("R5 stop one cycle", O_IDLE);
  endtask

  task automatic t_transfer();
    step(1'b1, 1'b0, "R3 start", O_STRT);
    hold("R3 busy", O_I2C);
    step(1'b0, 1'b0, "R4 b00", O_I2C);
    step(1'b0, 1'b1, "R4 b01", O_I2C);
    step(1'b1, 1'b1, "R4 b11", O_I2C);
    step(1'b0, 1'b1, "R4 b01 again", O_I2C);
    step(1'b0, 1'b0, "R4 b00 again", O_I2C);
    step(1'b1, 1'b0, "R4 b10", O_I2C);
    step(1'b1, 1'b1, "R5 stop", O_STOP);
    hold("R5 idle after stop", O_IDLE);
  endtask

  task automatic t_restart();
    step(1'b1, 1'b0, "R3 start", O_STRT);
    step(1'b0, 1'b0, "R4 b00", O_I2C);
    step(1'b0, 1'b1, "R4 b01", O_I2C);
    step(1'b1, 1'b1, "R4 b11", O_I2C);
    step(1'b1, 1'b0, "R6 repeated start", O_STRT);
    hold("R6 busy kept", O_I2C);
    step(1'b1, 1'b1, "R5 stop after restart", O_STOP);
  endtask

  task automatic t_spi();
    step(1'b0, 1'b1, "R7 clock first", O_SPI);
    step(1'b0, 1'b0, "R7 r00", O_SPI);
    step(1'b1, 1'b0, "R7 r10", O_SPI);
    step(1'b1, 1'b1, "R5 stop from r10", O_STOP);
    hold("R5 idle", O_IDLE);
    step(1'b0, 1'b1, "R7 clock first 2", O_SPI);
    step(1'b1, 1'b1, "R7 back to idle no stop", O_IDLE);
  endtask

  task automatic t_error();
    step(1'b0, 1'b0, "R8 double change", O_ERR);
    step(1'b1, 1'b1, "R8 sticky 11", O_ERR);
    step(1'b1, 1'b0, "R8 sticky 10", O_ERR);
    step(1'b0, 1'b1, "R8 sticky 01", O_ERR);
    do_reset();
    check("R8 cleared by reset", O_IDLE);
  endtask

  task automatic t_table();
    // state 0, input 01 -> state 2 with i2c flag
    tbl_write({4'd0, 2'b01}, {6'b010000, 4'd2});
    step(1'b0, 1'b1, "R9 rewritten entry", O_I2C);
    step(1'b0, 1'b0, "R9 default row after jump", O_I2C);
    step(1'b1, 1'b1, "R8 b00 to 11 traps", O_ERR);
    do_reset();
    step(1'b0, 1'b1, "R9 default restored", O_SPI);
    step(1'b1, 1'b1, "R7 idle", O_IDLE);
    // state 0, input 10 -> out-of-range next 12
    tbl_write({4'd0, 2'b10}, {6'b000000, 4'd12});
    step(1'b1, 1'b0, "R10 bad next traps", O_ERR);
    do_reset();
    check("R1 reset again", O_IDLE);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_transfer();
    t_restart();
    t_spi();
    t_error();
    t_table();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule